// File: doc/BRIEF.md
# ULPI PHY-Side Command Receiver

This block sits on the transceiver side of an 8-bit ULPI bus. While the link owns the bus (DIR low) it watches the data lines for a command byte. The two upper bits of that byte pick the command class, and the block paces the link with NXT. Register writes and reads with immediate addressing go to a simple register-file port. Packet-transmit commands are acknowledged and their bytes drained until STP, without being serialized.

When the transceiver side needs the bus it raises DIR, spends one turnaround cycle, drives one status byte and drops DIR again. This can happen in the middle of a link-started register operation, which is then abandoned without touching the register file; the link is expected to retry. The link may also assert STP during a turnaround cycle with DIR high, and DIR then falls on the next clock. Every change of bus ownership passes through a cycle in which neither side drives the data lines.

Top module: `ulpi_cmd_rx`

## Requirements
- R1: While `rstN` is low, `dir` is 1 and `nxt`, `dataOe` and `regWe` are 0. `dir` stays 1 until the first rising clock edge after `rstN` is released and is 0 from then on.
- R2: The command class sits in `dataIn[7:6]`: 2'b00 is a no-op, 2'b01 is packet transmit, 2'b10 is register write and 2'b11 is register read. A no-op byte leaves `nxt` and `dir` low.
- R3: A write byte `{2'b10, a[5:0]}` that the link presents in cycle c gives `nxt`=1 in cycles c+1 and c+2. The data byte is taken from `dataIn` in cycle c+2. If `stp` is 1 in cycle c+3, `regWe` pulses in that cycle with `regAddr`=a and `regWdata` equal to the data byte.
- R4: A write whose cycle c+3 has `stp`=0 is dropped. `regWe` stays 0, and a later read of that address returns the old value.
- R5: A read byte `{2'b11, a}` in cycle c gives `nxt`=1 in c+1, and `dir`=1 in c+2 and c+3. In c+2, `regRe`=1 and `regAddr`=a. In c+3, `dataOe`=1 and `dataOut` holds the register value. In c+4, `dir` and `dataOe` are both 0.
- R6: A transmit byte in cycle c gives `nxt`=1 from c+1 through the cycle in which `stp` is seen, and `nxt`=0 after it. The register port is not used.
- R7: If `phyClaim` is 1 in any cycle of a register operation before `dir` has risen (including the command cycle and the STP cycle of a write), `dir` is 1 on the next cycle and the operation ends without `regWe` or `regRe`. `phyClaim` during a packet drain has no effect, and `dir` stays 0.
- R8: A claim accepted in cycle k gives `dir`=1 in k+1 and k+2. In k+2, `dataOe`=1 and `dataOut` equals `statusByte` as sampled in k+1. `dir` is 0 in k+3.
- R9: If `stp` is 1 while `dir` is 1, `dir` is 0 on the next cycle. In a turnaround cycle this cancels the byte that was about to be driven.
- R10: `dataOe` is 1 only when `dir` is 1 in both the current and the previous cycle, and it is 0 in every cycle in which `dir` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 8 | Data lines as driven by the link |
| dataOut | output | 8 | Byte the PHY side drives onto the data lines |
| dataOe | output | 1 | Output enable for `dataOut` |
| dir | output | 1 | Bus direction, 1 when the PHY side owns the bus |
| stp | input | 1 | Stop / abort from the link |
| nxt | output | 1 | Byte-accept strobe towards the link |
| phyClaim | input | 1 | Request from the transceiver to take the bus and send status |
| statusByte | input | 8 | Status value sent when a claim is served |
| regAddr | output | 6 | Register-file address |
| regWdata | output | 8 | Register-file write data |
| regWe | output | 1 | Register-file write strobe |
| regRe | output | 1 | Register-file read strobe |
| regRdata | input | 8 | Register-file read data, combinational on `regAddr` |

## Verification
Every one of the 64 immediate addresses is written with its own arithmetic value and then read back. A dropped address bit or a swapped byte lane shows up as aliasing in this sweep. The same write is then replayed with a claim injected in each of its four cycles, and once with STP missing. Each variant must leave the old contents in place, which separates a commit that waits for STP from one that fires early. Packet drains with a claim pulse, no-op bytes, and STP during both kinds of turnaround show whether DIR and NXT follow the command class and release the bus on time.

// File: rtl/ulpi_cmd_pkg.sv
package ulpi_cmd_pkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_IDLE,
    ST_WR_CMD,
    ST_WR_DATA,
    ST_WR_STP,
    ST_TX,
    ST_RD_CMD,
    ST_RD_TURN,
    ST_RD_DRIVE,
    ST_CL_TURN,
    ST_CL_DRIVE
  } phyState_t;

  typedef enum logic [1:0] {
    CMD_NOOP = 2'b00,
    CMD_TX   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_RD   = 2'b11
  } cmdType_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capAddr;
    logic capData;
    logic commitWr;
    logic readReg;
    logic loadRd;
    logic loadSt;
    logic driveOe;
  } strobe_t;

endpackage

// File: rtl/ulpi_cmd_ctrl.sv
module ulpi_cmd_ctrl
  import ulpi_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    cmdTop,
  input  logic          stp,
  input  logic          phyClaim,
  output logic          dir,
  output logic          nxt,
  output strobe_t       strb
);

  phyState_t state, nextState;
  cmdType_t  cmdType;

  assign cmdType = cmdType_t'(cmdTop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_RESET: nextState = ST_IDLE;
      ST_IDLE: begin
        if (phyClaim) nextState = ST_CL_TURN;
        else begin
          unique case (cmdType)
            CMD_TX: nextState = ST_TX;
            CMD_WR: begin nextState = ST_WR_CMD; strb.capAddr = 1'b1; end
            CMD_RD: begin nextState = ST_RD_CMD; strb.capAddr = 1'b1; end
            default: nextState = ST_IDLE;
          endcase
        end
      end
      ST_WR_CMD:  nextState = phyClaim ? ST_CL_TURN : ST_WR_DATA;
      ST_WR_DATA: begin
        if (phyClaim) nextState = ST_CL_TURN;
        else begin nextState = ST_WR_STP; strb.capData = 1'b1; end
      end
      ST_WR_STP: begin
        if (phyClaim) nextState = ST_CL_TURN;
        else begin
          nextState     = ST_IDLE;
          strb.commitWr = stp;
        end
      end
      ST_TX:      if (stp) nextState = ST_IDLE;
      ST_RD_CMD:  nextState = phyClaim ? ST_CL_TURN : ST_RD_TURN;
      ST_RD_TURN: begin
        strb.readReg = 1'b1;
        if (stp) nextState = ST_IDLE;
        else begin nextState = ST_RD_DRIVE; strb.loadRd = 1'b1; end
      end
      ST_RD_DRIVE: begin strb.driveOe = 1'b1; nextState = ST_IDLE; end
      ST_CL_TURN: begin
        if (stp) nextState = ST_IDLE;
        else begin nextState = ST_CL_DRIVE; strb.loadSt = 1'b1; end
      end
      ST_CL_DRIVE: begin strb.driveOe = 1'b1; nextState = ST_IDLE; end
      default: nextState = ST_IDLE;
    endcase
  end

  assign dir = state inside {ST_RESET, ST_RD_TURN, ST_RD_DRIVE, ST_CL_TURN, ST_CL_DRIVE};
  assign nxt = state inside {ST_WR_CMD, ST_WR_DATA, ST_TX, ST_RD_CMD};

endmodule

// File: rtl/ulpi_cmd_dp.sv
module ulpi_cmd_dp
  import ulpi_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] regRdata,
  input  logic [DATA_W-1:0] statusByte,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] outQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      outQ   <= '0;
    end else begin
      if (strb.capAddr) addrQ  <= dataIn[ADDR_W-1:0];
      if (strb.capData) wdataQ <= dataIn;
      if (strb.loadRd)      outQ <= regRdata;
      else if (strb.loadSt) outQ <= statusByte;
    end
  end

  assign regAddr  = addrQ;
  assign regWdata = wdataQ;
  assign regWe    = strb.commitWr;
  assign regRe    = strb.readReg;
  assign dataOut  = outQ;
  assign dataOe   = strb.driveOe;

endmodule

// File: rtl/ulpi_cmd_rx.sv
module ulpi_cmd_rx
  import ulpi_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TYPE_W = 2,
  localparam int ADDR_W = DATA_W - TYPE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              dir,
  input  logic              stp,
  output logic              nxt,
  input  logic              phyClaim,
  input  logic [DATA_W-1:0] statusByte,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  strobe_t strb;

  ulpi_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdTop   (dataIn[DATA_W-1 -: TYPE_W]),
    .stp      (stp),
    .phyClaim (phyClaim),
    .dir      (dir),
    .nxt      (nxt),
    .strb     (strb)
  );

  ulpi_cmd_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dataIn     (dataIn),
    .regRdata   (regRdata),
    .statusByte (statusByte),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regWe      (regWe),
    .regRe      (regRe)
  );

endmodule

// File: rtl/ulpi_cmd_rx_chk.sv
module ulpi_cmd_rx_chk (
  input logic clk,
  input logic rstN,
  input logic dir,
  input logic nxt,
  input logic stp,
  input logic dataOe,
  input logic phyClaim,
  input logic regWe,
  input logic regRe
);

  // R1: bus held by the PHY side while reset is active
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_owns_bus: assert (dir && !nxt && !dataOe && !regWe)
        else $error("R1 reset outputs wrong");
    end
  end

  // R10: drive only after a full turnaround with DIR high
  a_r10_oe_after_turn: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dir && $past(dir)));

  // R9: STP while DIR high releases the bus on the next clock
  a_r9_stp_releases: assert property (@(posedge clk) disable iff (!rstN)
    (dir && stp) |=> !dir);

  // R3: a commit follows an NXT-accepted data byte and coincides with STP
  a_r3_commit_on_stp: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> ($past(nxt) && !nxt && stp && !dir));

  // R7: a claim never coexists with a commit
  a_r7_claim_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    phyClaim |-> !regWe);

  // R5: an unaborted read strobe is followed by the drive cycle
  a_r5_read_then_drive: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && !stp) |=> (dir && dataOe));

  // R2: NXT is only given while the link owns the bus
  a_r2_nxt_link_side: assert property (@(posedge clk) disable iff (!rstN)
    nxt |-> !dir);

endmodule

bind ulpi_cmd_rx ulpi_cmd_rx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dir      (dir),
  .nxt      (nxt),
  .stp      (stp),
  .dataOe   (dataOe),
  .phyClaim (phyClaim),
  .regWe    (regWe),
  .regRe    (regRe)
);

// File: tb/tb_ulpi_cmd_rx.sv
module tb_ulpi_cmd_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;
  logic       dir;
  logic       stp = 1'b0;
  logic       nxt;
  logic       phyClaim = 1'b0;
  logic [7:0] statusByte = 8'h00;
  logic [5:0] regAddr;
  logic [7:0] regWdata;
  logic       regWe;
  logic       regRe;
  logic [7:0] regRdata;

  logic [7:0] mem [64];
  logic [7:0] expv [64];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ulpi_cmd_rx dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .dir(dir), .stp(stp), .nxt(nxt), .phyClaim(phyClaim), .statusByte(statusByte),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata)
  );

  // bench-side register file model
  assign regRdata = mem[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
    end else if (regWe) begin
      mem[regAddr] <= regWdata;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [7:0] d, input bit withStp);
    @(negedge clk); dataIn = {2'b10, a}; #1;
    chk("R2", "no nxt in command cycle", nxt, 0);
    @(negedge clk); #1;
    chk("R3", "nxt on command", nxt, 1);
    @(negedge clk); dataIn = d; #1;
    chk("R3", "nxt on data", nxt, 1);
    chk("R3", "no early write", regWe, 0);
    @(negedge clk); dataIn = 8'h00; stp = withStp; #1;
    chk("R3", "nxt low at stp", nxt, 0);
    if (withStp) begin
      chk("R3", "write strobe", regWe, 1);
      chk("R3", "write address", regAddr, a);
      chk("R3", "write data", regWdata, d);
    end else begin
      chk("R4", "no write without stp", regWe, 0);
    end
    @(negedge clk); stp = 1'b0; #1;
    chk("R3", "single write pulse", regWe, 0);
  endtask

  task automatic rdReg(input logic [5:0] a, input logic [7:0] e, input string req);
    @(negedge clk); dataIn = {2'b11, a}; #1;
    @(negedge clk); #1;
    chk("R5", "nxt on read command", nxt, 1);
    chk("R5", "dir low on read command", dir, 0);
    @(negedge clk); dataIn = 8'h00; #1;
    chk("R5", "dir in turnaround", dir, 1);
    chk("R10", "no drive in turnaround", dataOe, 0);
    chk("R5", "read strobe", regRe, 1);
    chk("R5", "read address", regAddr, a);
    @(negedge clk); #1;
    chk("R5", "dir in drive cycle", dir, 1);
    chk("R5", "oe in drive cycle", dataOe, 1);
    chk(req, "read data", dataOut, e);
    @(negedge clk); #1;
    chk("R5", "dir released", dir, 0);
    chk("R10", "oe released", dataOe, 0);
  endtask

  // claim injected in cycle 'at' of a write or read sequence
  task automatic claimRun(input bit isRead, input logic [5:0] a, input logic [7:0] d,
                          input int at, input logic [7:0] st);
    logic [7:0] cmd;
    cmd = {(isRead ? 2'b11 : 2'b10), a};
    statusByte = st;
    for (int k = 0; k <= at + 3; k++) begin
      @(negedge clk);
      phyClaim = (k == at);
      if (k <= at) begin
        dataIn = (k <= 1) ? cmd : ((k == 2) ? d : 8'h00);
        stp = (k == 3);
      end else begin
        dataIn = 8'h00;
        stp = 1'b0;
      end
      #1;
      chk("R7", "dir around claim", dir, int'((k == at + 1) || (k == at + 2)));
      chk("R10", "oe around claim", dataOe, int'(k == at + 2));
      chk("R7", "no write on abort", regWe, 0);
      chk("R7", "no read on abort", regRe, 0);
      if (k == at + 2) chk("R8", "status byte driven", dataOut, st);
    end
    @(negedge clk); phyClaim = 1'b0; stp = 1'b0; dataIn = 8'h00; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "dir in reset", dir, 1);
    chk("R1", "nxt in reset", nxt, 0);
    chk("R1", "oe in reset", dataOe, 0);
    chk("R1", "we in reset", regWe, 0);
    @(negedge clk); rstN = 1'b1; #1;
    chk("R1", "dir before first edge", dir, 1);
    @(negedge clk); #1;
    chk("R1", "dir after release", dir, 0);

    // R2 no-op bytes
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); dataIn = 8'h2A + 8'(k); #1;
      chk("R2", "no nxt for no-op", nxt, 0);
      chk("R2", "no dir for no-op", dir, 0);
    end
    @(negedge clk); dataIn = 8'h00;

    // R3 / R5 full address sweep
    for (int a = 0; a < 64; a++) begin
      expv[a] = 8'((a * 37 + 11) & 255);
      wrReg(6'(a), expv[a], 1'b1);
    end
    for (int a = 0; a < 64; a++) rdReg(6'(a), expv[a], "R5");

    // R4 write without STP
    wrReg(6'd5, ~expv[5], 1'b0);
    rdReg(6'd5, expv[5], "R4");

    // R7 / R8 claims in each write cycle, and in both read command cycles
    for (int at = 0; at < 4; at++) begin
      claimRun(1'b0, 6'(10 + at), 8'hC3, at, 8'(8'h90 + at));
      rdReg(6'(10 + at), expv[10 + at], "R7");
    end
    for (int at = 0; at < 2; at++) claimRun(1'b1, 6'd20, 8'h00, at, 8'(8'h60 + at));

    // R6 packet drain with an ignored claim
    @(negedge clk); dataIn = 8'h43; #1;
    @(negedge clk); #1;
    chk("R6", "nxt on transmit command", nxt, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); dataIn = 8'(8'h10 + k); phyClaim = (k == 1); #1;
      chk("R6", "nxt while draining", nxt, 1);
      chk("R7", "claim ignored in drain", dir, 0);
      chk("R6", "no register write in drain", regWe, 0);
    end
    @(negedge clk); phyClaim = 1'b0; dataIn = 8'h00; stp = 1'b1; #1;
    chk("R6", "nxt on stp cycle", nxt, 1);
    @(negedge clk); stp = 1'b0; #1;
    chk("R6", "nxt after stp", nxt, 0);
    chk("R6", "dir after stp", dir, 0);

    // R9 STP abort during claim turnaround
    statusByte = 8'h5A;
    @(negedge clk); phyClaim = 1'b1; #1;
    @(negedge clk); phyClaim = 1'b0; stp = 1'b1; #1;
    chk("R9", "dir in claim turnaround", dir, 1);
    @(negedge clk); stp = 1'b0; #1;
    chk("R9", "dir after stp abort", dir, 0);
    chk("R9", "no drive after stp abort", dataOe, 0);

    // R9 STP abort during read turnaround
    @(negedge clk); dataIn = 8'hC0 | 8'd33; #1;
    @(negedge clk); #1;
    @(negedge clk); dataIn = 8'h00; stp = 1'b1; #1;
    chk("R9", "dir in read turnaround", dir, 1);
    @(negedge clk); stp = 1'b0; #1;
    chk("R9", "dir after read abort", dir, 0);
    chk("R9", "no read drive after abort", dataOe, 0);

    // contents intact after all aborts
    rdReg(6'd33, expv[33], "R9");
    rdReg(6'd63, expv[63], "R3");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule